// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Software Rearm

This block is the receive half of an asynchronous serial port. It watches a serial input line, spots the start of each character on a 16x oversampling tick, and shifts in eight data bits. The first bit on the line is the least significant bit. It then checks the stop bit and hands the finished character to a one-entry receive buffer.

Software reads the buffer and then writes a rearm strobe. The strobe declares the buffer empty and ready for the next character. A character that finishes while the buffer is not armed is not stored. It sets a sticky overrun flag instead. This covers a character that lands after software has read the byte but before it has written the rearm. The armed state is visible as a status bit: 1 means the receiver will accept a character, and 0 means reception has stopped until the next rearm. Clearing the enable input stops reception altogether.

Top module: `uart_rx_rearm`

## Requirements
- R1: After reset, `rx_active`, `data_ready`, `overrun` and `frame_err` are 0 and `rx_data` is 0x00.
- R2: A `rearm_wr` pulse while `rx_en` is 1 sets `rx_active` to 1 and clears `data_ready` and `frame_err`. A `rearm_wr` pulse while `rx_en` is 0 has no effect, so `rx_active` stays 0.
- R3: Each character has 8 data bits, least significant bit first, and each bit lasts 16 ticks of `baud_tick`. When a character completes with `rx_active` at 1, the next clock loads `rx_data`, sets `data_ready` to 1 and clears `rx_active` to 0.
- R4: A falling edge on `rxd` is resampled 8 ticks later, at the centre of the start bit. If the line is high again there, the receiver returns to idle: nothing is loaded and `rx_active` stays 1.
- R5: When a character completes with `rx_active` at 0, `overrun` is set to 1 and `rx_data` keeps its old value.
- R6: `overrun` stays at 1 until an `ovr_clr` pulse clears it. A new overrun in the same cycle as the clear wins, and the flag stays at 1.
- R7: The stop bit is sampled 16 ticks after the last data bit. When the buffer is loaded, `frame_err` takes the value 1 if the stop bit was low and 0 if it was high.
- R8: Driving `rx_en` to 0 aborts any character in progress and clears `rx_active` by the next clock. While `rx_en` is 0, no character completes and neither `data_ready` nor `overrun` is set.
- R9: If a character completes in the same cycle as a `rearm_wr`, the rearm state before that edge decides the outcome. If the receiver was armed, the character is loaded and the rearm is discarded. If it was not armed, the character counts as an overrun and the rearm takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receive enable; 0 stops and aborts reception |
| rearm_wr | input | 1 | Strobe: mark the buffer empty and arm reception |
| ovr_clr | input | 1 | Strobe: clear the overrun flag |
| rx_active | output | 1 | Status: 1 = armed, 0 = reception stopped |
| data_ready | output | 1 | Buffer holds an unread character |
| rx_data | output | 8 | Buffered character |
| overrun | output | 1 | Sticky overrun flag |
| frame_err | output | 1 | Stop bit of the buffered character was low |

## Verification
The assertions check on every cycle how a completed character is handled at the buffer. A completion while armed must load the buffer and disarm it. A completion while unarmed must set the overrun flag and leave the stored byte alone. The checks also cover the stickiness of the overrun flag, the effect of a rearm, and the receiver going idle while disabled. Only the bench scenarios can show the behaviour on the serial line itself. These scenarios check that bits are assembled least significant bit first at the right sample points, that a short low glitch is rejected at the start-bit centre, that a low stop bit raises the framing flag, and that a frame cut off by disabling leaves no trace.

// File: rtl/rxr_pkg.sv
// Package: shared types for the rearm-style serial receiver.
// Assumes: nothing; holds only the deframer state encoding.
package rxr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_DATA  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/rxr_sync.sv
// Module: rxr_sync
// Brings the asynchronous serial line into the clock domain through a
// chain of flops. Assumes STAGES >= 1 and a line that idles high.
module rxr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // Purpose: one flop of the synchronizer chain, reset to idle level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else if (g == 0) chain[g] <= d_in;
                else chain[g] <= chain[(g > 0) ? g - 1 : 0];
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/rxr_deframer.sv
// Module: rxr_deframer
// Finds a start bit on a falling edge, confirms it at the bit centre, and
// samples the data bits (least significant first) and the stop bit once per
// OVERSAMPLE ticks. Emits a one-cycle done pulse with the byte and stop level.
// Assumes: line already synchronized; en low forces idle and aborts a frame.
module rxr_deframer
    import rxr_pkg::*;
#(
    parameter int DATA_BITS  = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 line,
    output logic                 done,
    output logic [DATA_BITS-1:0] byte_out,
    output logic                 stop_ok
);
    localparam int CNT_W = $clog2(OVERSAMPLE);
    localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVERSAMPLE - 1);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_BITS - 1);

    rx_state_t             state;
    logic [CNT_W-1:0]      cnt;
    logic [IDX_W-1:0]      idx;
    logic                  was_high;
    logic [DATA_BITS-1:0]  shreg;

    // Purpose: frame state machine driven by the oversampling tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            idx      <= '0;
            was_high <= 1'b0;
            shreg    <= '0;
            done     <= 1'b0;
            stop_ok  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    ST_IDLE: begin
                        was_high <= line;
                        cnt      <= '0;
                        if (was_high && !line) state <= ST_START;
                    end
                    ST_START: begin
                        if (cnt == HALF_LAST) begin
                            cnt <= '0;
                            idx <= '0;
                            if (!line) begin
                                state <= ST_DATA;
                            end else begin
                                state    <= ST_IDLE;
                                was_high <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (cnt == FULL_LAST) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[DATA_BITS-1:1]};
                            if (idx == IDX_LAST) state <= ST_STOP;
                            else idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt == FULL_LAST) begin
                            cnt      <= '0;
                            done     <= 1'b1;
                            stop_ok  <= line;
                            was_high <= line;
                            state    <= ST_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign byte_out = shreg;
endmodule

// File: rtl/rxr_buffer.sv
// Module: rxr_buffer
// One-entry receive buffer with an explicit rearm handshake. A completed
// character is stored only while armed; otherwise it raises a sticky
// overrun. Assumes done is a single-cycle pulse.
module rxr_buffer #(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic                 rearm_wr,
    input  logic                 ovr_clr,
    input  logic                 done,
    input  logic [DATA_BITS-1:0] byte_in,
    input  logic                 stop_ok,
    output logic                 armed,
    output logic                 ready,
    output logic [DATA_BITS-1:0] data,
    output logic                 ferr,
    output logic                 ovr
);
    logic accept;
    logic reject;

    assign accept = en && done && armed;
    assign reject = en && done && !armed;

    // Purpose: load on an armed completion, otherwise apply a rearm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            ready <= 1'b0;
            data  <= '0;
            ferr  <= 1'b0;
        end else if (!en) begin
            armed <= 1'b0;
        end else if (accept) begin
            data  <= byte_in;
            ready <= 1'b1;
            ferr  <= !stop_ok;
            armed <= 1'b0;
        end else if (rearm_wr) begin
            armed <= 1'b1;
            ready <= 1'b0;
            ferr  <= 1'b0;
        end
    end

    // Purpose: sticky overrun flag; setting wins over clearing.
    always_ff @(posedge clk) begin
        if (!rst_n)       ovr <= 1'b0;
        else if (reject)  ovr <= 1'b1;
        else if (ovr_clr) ovr <= 1'b0;
    end
endmodule

// File: rtl/uart_rx_rearm.sv
// Module: uart_rx_rearm (top)
// Asynchronous serial receiver: synchronizer, deframer and a rearm-handshake
// buffer. Assumes baud_tick pulses for one clock at OVERSAMPLE times the
// bit rate and that rxd idles high.
module uart_rx_rearm #(
    parameter int DATA_BITS   = 8,
    parameter int OVERSAMPLE  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 rxd,
    input  logic                 rx_en,
    input  logic                 rearm_wr,
    input  logic                 ovr_clr,
    output logic                 rx_active,
    output logic                 data_ready,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 overrun,
    output logic                 frame_err
);
    logic                 line_s;
    logic                 frm_done;
    logic [DATA_BITS-1:0] frm_byte;
    logic                 frm_stop;

    rxr_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rxd),
        .d_out (line_s)
    );

    rxr_deframer #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_deframer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .tick     (baud_tick),
        .line     (line_s),
        .done     (frm_done),
        .byte_out (frm_byte),
        .stop_ok  (frm_stop)
    );

    rxr_buffer #(.DATA_BITS(DATA_BITS)) u_buffer (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (rx_en),
        .rearm_wr (rearm_wr),
        .ovr_clr  (ovr_clr),
        .done     (frm_done),
        .byte_in  (frm_byte),
        .stop_ok  (frm_stop),
        .armed    (rx_active),
        .ready    (data_ready),
        .data     (rx_data),
        .ferr     (frame_err),
        .ovr      (overrun)
    );
endmodule

// File: rtl/uart_rx_rearm_checker.sv
// Module: uart_rx_rearm_checker
// Cycle-level properties of the buffer handshake, bound into the top.
// Assumes: done is the deframer's completion pulse.
module uart_rx_rearm_checker #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 rx_en,
    input logic                 rearm_wr,
    input logic                 ovr_clr,
    input logic                 done,
    input logic                 rx_active,
    input logic                 data_ready,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 overrun,
    input logic                 frame_err
);
    a_r3_load_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && done && rx_active |=> data_ready && !rx_active);

    a_r3_rise_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_ready) |-> !rx_active);

    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && done && !rx_active |=> overrun);

    a_r5_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && done && !rx_active |=> $stable(rx_data));

    a_r6_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !ovr_clr |=> overrun);

    a_r2_rearm_effect: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && rearm_wr && !done |=> rx_active && !data_ready && !frame_err);

    a_r8_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !rx_active && !done);

    a_r9_rearm_after_reject: assert property (@(posedge clk) disable iff (!rst_n)
        rx_en && done && !rx_active && rearm_wr |=> rx_active && overrun);
endmodule

bind uart_rx_rearm uart_rx_rearm_checker #(.DATA_BITS(DATA_BITS)) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .rearm_wr   (rearm_wr),
    .ovr_clr    (ovr_clr),
    .done       (frm_done),
    .rx_active  (rx_active),
    .data_ready (data_ready),
    .rx_data    (rx_data),
    .overrun    (overrun),
    .frame_err  (frame_err)
);

// File: tb/uart_rx_rearm_bench.sv
// Bench: directed scenarios for uart_rx_rearm, one task per scenario.
module uart_rx_rearm_bench;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLKS = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b0;
    logic       rearm_wr = 1'b0;
    logic       ovr_clr = 1'b0;
    logic       rx_active;
    logic       data_ready;
    logic [7:0] rx_data;
    logic       overrun;
    logic       frame_err;

    int checks = 0;
    int errors = 0;
    int div_cnt = 0;

    uart_rx_rearm u_uart_rx_rearm (
        .clk        (clk),
        .rst_n      (rst_n),
        .baud_tick  (baud_tick),
        .rxd        (rxd),
        .rx_en      (rx_en),
        .rearm_wr   (rearm_wr),
        .ovr_clr    (ovr_clr),
        .rx_active  (rx_active),
        .data_ready (data_ready),
        .rx_data    (rx_data),
        .overrun    (overrun),
        .frame_err  (frame_err)
    );

    always #4 clk = ~clk;

    // Purpose: oversampling tick, one clock in every TICK_DIV.
    always @(negedge clk) begin
        div_cnt   <= (div_cnt == TICK_DIV - 1) ? 0 : div_cnt + 1;
        baud_tick <= (div_cnt == TICK_DIV - 1);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_rearm();
        @(negedge clk) rearm_wr = 1'b1;
        @(negedge clk) rearm_wr = 1'b0;
    endtask

    task automatic pulse_ovr_clr();
        @(negedge clk) ovr_clr = 1'b1;
        @(negedge clk) ovr_clr = 1'b0;
    endtask

    // Start bit, 8 data bits with bit 0 first, then the given stop level.
    task automatic send_frame(input logic [7:0] b, input logic stop);
        @(negedge clk) rxd = 1'b0;
        idle(BIT_CLKS);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            idle(BIT_CLKS);
        end
        rxd = stop;
        idle(BIT_CLKS);
        rxd = 1'b1;
        idle(2 * BIT_CLKS);
    endtask

    task automatic t_reset();
        check("R1 rx_active", rx_active, 0);
        check("R1 data_ready", data_ready, 0);
        check("R1 overrun", overrun, 0);
        check("R1 frame_err", frame_err, 0);
        check("R1 rx_data", rx_data, 0);
    endtask

    task automatic t_rearm_disabled();
        rx_en = 1'b0;
        pulse_rearm();
        idle(2);
        check("R2 rearm ignored when disabled", rx_active, 0);
        rx_en = 1'b1;
        idle(2 * BIT_CLKS);
        pulse_rearm();
        idle(1);
        check("R2 rearm arms", rx_active, 1);
    endtask

    task automatic t_receive_good();
        send_frame(8'hA5, 1'b1);
        check("R3 data", rx_data, 8'hA5);
        check("R3 data_ready", data_ready, 1);
        check("R3 disarmed", rx_active, 0);
        check("R7 good stop", frame_err, 0);
    endtask

    task automatic t_overrun();
        send_frame(8'h5A, 1'b1);
        check("R5 overrun set", overrun, 1);
        check("R5 data kept", rx_data, 8'hA5);
        idle(BIT_CLKS);
        check("R6 overrun sticky", overrun, 1);
        pulse_ovr_clr();
        idle(1);
        check("R6 overrun cleared", overrun, 0);
    endtask

    task automatic t_frame_error();
        pulse_rearm();
        idle(1);
        check("R2 rearm clears ready", data_ready, 0);
        send_frame(8'h3C, 1'b0);
        check("R7 data with bad stop", rx_data, 8'h3C);
        check("R7 frame_err", frame_err, 1);
        pulse_rearm();
        idle(1);
        check("R2 rearm clears frame_err", frame_err, 0);
    endtask

    task automatic t_glitch();
        @(negedge clk) rxd = 1'b0;
        idle(3 * TICK_DIV);
        rxd = 1'b1;
        idle(12 * BIT_CLKS);
        check("R4 glitch no load", data_ready, 0);
        check("R4 still armed", rx_active, 1);
        send_frame(8'h81, 1'b1);
        check("R4 receive after glitch", rx_data, 8'h81);
    endtask

    task automatic t_disable_abort();
        pulse_rearm();
        @(negedge clk) rxd = 1'b0;
        idle(BIT_CLKS);
        rxd = 1'b1;
        idle(2 * BIT_CLKS);
        rx_en = 1'b0;
        idle(2);
        check("R8 disable clears active", rx_active, 0);
        rxd = 1'b0;
        idle(7 * BIT_CLKS);
        rxd = 1'b1;
        idle(2 * BIT_CLKS);
        check("R8 no completion ready", data_ready, 0);
        check("R8 no overrun", overrun, 0);
        check("R8 buffer unchanged", rx_data, 8'h81);
        rx_en = 1'b1;
        idle(2 * BIT_CLKS);
        pulse_rearm();
        send_frame(8'h0F, 1'b1);
        check("R8 recovery after enable", rx_data, 8'h0F);
    endtask

    // Purpose: watchdog; an expired run counts as a failed check.
    initial begin
        #(8 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_rearm_disabled();
        t_receive_good();
        t_overrun();
        t_frame_error();
        t_glitch();
        t_disable_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule